// File: doc/BRIEF.md
# Nonvolatile Register Store Controller

This block keeps a bank of small data registers that stand in for nonvolatile storage beside a digitally controlled wiper. A serial command decoder hands it write requests of two kinds: a value supplied by the host, or a copy of the present wiper position. The block holds such a request until the decoder reports that chip select has risen at the end of a complete frame. Only then does it start a modelled internal write. That write lasts a fixed, parameterized number of clock cycles. During the write a busy flag is raised, and status reads use this flag.

A write-protect input, active low, cancels a commit that would otherwise start. The wiper register sits outside this block and is never affected by it. Register zero is always presented on a separate output, so the wiper logic can recall it at power-up. Any register can be read combinationally at any time. A logic reset clears the request and the timer but leaves the stored values alone. A separate power-on model input clears the stored values.

Top module: `nv_store_ctrl`

## Requirements
- R1: After a logic reset, `write_busy` and `req_dropped` are low, and stored register values are kept unchanged across the reset.
- R2: `por_clear` high at a clock edge sets all registers to zero.
- R3: A request with `req_src`=0 captures `req_data` for register `req_ptr` (2-bit pointer, registers 0..3). The register does not change before the commit ends.
- R4: A request with `req_src`=1 captures `wiper_val` as it was in the request cycle. Later changes of `wiper_val` have no effect on the value committed.
- R5: A commit starts at a clock edge where `frame_end` and `frame_complete` are high, `wr_protect_n` is high, a request is held, and no write is running. `write_busy` is then high for exactly `COMMIT_CYCLES` cycles, starting the cycle after that edge.
- R6: `write_busy` falls in the same cycle in which the register shows the committed value.
- R7: If `wr_protect_n` is low when the frame ends, the request is discarded: no busy interval occurs and no register changes.
- R8: A `frame_end` without `frame_complete` discards the held request: no busy interval occurs and no register changes.
- R9: A request that arrives while `write_busy` is high is dropped. `req_dropped` is high for the one following cycle, and a later complete frame end does not commit that request.
- R10: `recall_val` always equals register zero.
- R11: `rd_data` is the register chosen by `rd_ptr` at any time. While a write is running, it still shows the old value of the target register.
- R12: When several requests arrive within one frame, the last one is the one committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous logic reset, active low; storage is kept |
| por_clear | input | 1 | Power-on model: clears all registers |
| req_valid | input | 1 | One-cycle nonvolatile write request from the decoder |
| req_src | input | 1 | 0 = host value, 1 = copy of wiper |
| req_ptr | input | 2 | Target register |
| req_data | input | 6 | Host-supplied value |
| wiper_val | input | 6 | Present wiper register value |
| frame_end | input | 1 | Chip select rose (one-cycle pulse) |
| frame_complete | input | 1 | Qualifies `frame_end`: the frame was whole |
| wr_protect_n | input | 1 | Low blocks nonvolatile commits |
| rd_ptr | input | 2 | Read register select |
| rd_data | output | 6 | Selected register value |
| recall_val | output | 6 | Register zero for power-up recall |
| write_busy | output | 1 | Internal write in progress |
| req_dropped | output | 1 | A request was lost to a running write |

## Verification
`write_busy` rises one cycle after the clock edge that samples the closing `frame_end`. The value stays unchanged on `rd_data` until the edge `COMMIT_CYCLES` later, where the busy flag clears and the new value appears at once. `req_dropped` is due one cycle after the refused request. The bench drives inputs on falling edges and samples on the next falling edge, so each result is read half a cycle after the edge that makes it. It counts busy cycles per falling edge and compares the count with `COMMIT_CYCLES`. The read port is combinational and is checked a short delay after `rd_ptr` changes.

// File: rtl/nv_store_pkg.sv
package nv_store_pkg;

  typedef enum logic {
    SRC_HOST  = 1'b0,
    SRC_WIPER = 1'b1
  } nv_src_e;

  // Value a request will commit, given its source.
  function automatic logic [31:0] pick_source(input logic src, input logic [31:0] host_v,
                                              input logic [31:0] wiper_v);
    return (nv_src_e'(src) == SRC_WIPER) ? wiper_v : host_v;
  endfunction

  // Down-counter step that saturates at zero.
  function automatic int unsigned count_down(input int unsigned c);
    return (c == 0) ? 0 : c - 1;
  endfunction

endpackage

// File: rtl/nv_req_latch.sv
module nv_req_latch #(
  parameter int DATA_W = 6,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_src,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] wiper_val,
  input  logic              busy,
  input  logic              frame_end,
  output logic              armed,
  output logic [PTR_W-1:0]  arm_ptr,
  output logic [DATA_W-1:0] arm_data,
  output logic              dropped
);
  import nv_store_pkg::*;

  logic take;
  logic [DATA_W-1:0] chosen;

  assign take   = req_valid && !busy;
  assign chosen = DATA_W'(pick_source(req_src, 32'(req_data), 32'(wiper_val)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      arm_ptr  <= '0;
      arm_data <= '0;
      dropped  <= 1'b0;
    end else begin
      dropped <= req_valid && busy;
      if (frame_end) begin
        armed <= 1'b0;
      end else if (take) begin
        armed    <= 1'b1;
        arm_ptr  <= req_ptr;
        arm_data <= chosen;
      end
    end
  end
endmodule

// File: rtl/nv_commit_timer.sv
module nv_commit_timer #(
  parameter int COMMIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fire
);
  import nv_store_pkg::*;

  localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(COMMIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign fire = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD_V;
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= CNT_W'(count_down(32'(cnt)));
    end
  end
endmodule

// File: rtl/nv_reg_bank.sv
module nv_reg_bank #(
  parameter int DATA_W = 6,
  parameter int REGS   = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              por_clear,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] reg0
);
  logic [REGS*DATA_W-1:0] flat;

  for (genvar g = 0; g < REGS; g++) begin : g_cell
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (por_clear)
        q <= '0;
      else if (wr_en && (wr_ptr == PTR_W'(g)))
        q <= wr_data;
    end
    assign flat[g*DATA_W +: DATA_W] = q;
  end

  assign rd_data = flat[int'(rd_ptr)*DATA_W +: DATA_W];
  assign reg0    = flat[DATA_W-1:0];
endmodule

// File: rtl/nv_store_ctrl.sv
module nv_store_ctrl #(
  parameter int DATA_W        = 6,
  parameter int REGS          = 4,
  parameter int COMMIT_CYCLES = 16,
  localparam int PTR_W        = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_clear,
  input  logic              req_valid,
  input  logic              req_src,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [DATA_W-1:0] wiper_val,
  input  logic              frame_end,
  input  logic              frame_complete,
  input  logic              wr_protect_n,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] recall_val,
  output logic              write_busy,
  output logic              req_dropped
);
  // Named internal events, also seen by the bound checker.
  logic              armed_q;
  logic [PTR_W-1:0]  arm_ptr;
  logic [DATA_W-1:0] arm_data;
  logic              commit_start;
  logic              commit_fire;

  assign commit_start = frame_end && frame_complete && wr_protect_n && armed_q && !write_busy;

  nv_req_latch #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_ptr   (req_ptr),
    .req_data  (req_data),
    .wiper_val (wiper_val),
    .busy      (write_busy),
    .frame_end (frame_end),
    .armed     (armed_q),
    .arm_ptr   (arm_ptr),
    .arm_data  (arm_data),
    .dropped   (req_dropped)
  );

  nv_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_start),
    .busy  (write_busy),
    .fire  (commit_fire)
  );

  nv_reg_bank #(.DATA_W(DATA_W), .REGS(REGS), .PTR_W(PTR_W)) u_bank (
    .clk       (clk),
    .por_clear (por_clear),
    .wr_en     (commit_fire),
    .wr_ptr    (arm_ptr),
    .wr_data   (arm_data),
    .rd_ptr    (rd_ptr),
    .rd_data   (rd_data),
    .reg0      (recall_val)
  );
endmodule

// File: rtl/nv_store_chk.sv
module nv_store_chk #(
  parameter int DATA_W        = 6,
  parameter int PTR_W         = 2,
  parameter int COMMIT_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_clear,
  input logic              req_valid,
  input logic              frame_end,
  input logic              frame_complete,
  input logic              wr_protect_n,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] recall_val,
  input logic              write_busy,
  input logic              req_dropped,
  input logic              armed,
  input logic              commit_fire
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_len <= 0;
    else if (write_busy) busy_len <= busy_len + 1;
    else                 busy_len <= 0;
  end

  p_recall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr == '0 && !por_clear) |-> (rd_data == recall_val));

  p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame_complete && wr_protect_n && armed && !write_busy) |=> write_busy);

  p_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_busy) |-> (busy_len == COMMIT_CYCLES));

  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> !write_busy);

  p_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !wr_protect_n && !write_busy) |=> !write_busy);

  p_incomplete_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_complete && !write_busy) |=> !write_busy);

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && write_busy) |=> req_dropped);

  p_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && write_busy) |=> !req_dropped);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (write_busy && $past(write_busy) && $stable(rd_ptr) && !por_clear && !$past(por_clear))
      |-> $stable(rd_data));
endmodule

bind nv_store_ctrl nv_store_chk #(
  .DATA_W(DATA_W), .PTR_W(PTR_W), .COMMIT_CYCLES(COMMIT_CYCLES)
) u_nv_store_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .por_clear      (por_clear),
  .req_valid      (req_valid),
  .frame_end      (frame_end),
  .frame_complete (frame_complete),
  .wr_protect_n   (wr_protect_n),
  .rd_ptr         (rd_ptr),
  .rd_data        (rd_data),
  .recall_val     (recall_val),
  .write_busy     (write_busy),
  .req_dropped    (req_dropped),
  .armed          (armed_q),
  .commit_fire    (commit_fire)
);

// File: tb/test_nv_store_ctrl.sv
module test_nv_store_ctrl;
  localparam int CYC = 16;

  logic       clk = 1'b0;
  logic       rst_n, por_clear, req_valid, req_src, frame_end, frame_complete, wr_protect_n;
  logic [1:0] req_ptr, rd_ptr;
  logic [5:0] req_data, wiper_val, rd_data, recall_val;
  logic       write_busy, req_dropped;

  int total = 0;
  int bad   = 0;
  logic [5:0] model [4];

  always #4 clk = ~clk;

  nv_store_ctrl #(.DATA_W(6), .REGS(4), .COMMIT_CYCLES(CYC)) i_nv_store_ctrl (
    .clk(clk), .rst_n(rst_n), .por_clear(por_clear), .req_valid(req_valid),
    .req_src(req_src), .req_ptr(req_ptr), .req_data(req_data), .wiper_val(wiper_val),
    .frame_end(frame_end), .frame_complete(frame_complete), .wr_protect_n(wr_protect_n),
    .rd_ptr(rd_ptr), .rd_data(rd_data), .recall_val(recall_val),
    .write_busy(write_busy), .req_dropped(req_dropped)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bench view of what a request commits: wiper copy when source is 1.
  function automatic logic [5:0] expect_value(input logic src, input logic [5:0] host_v,
                                              input logic [5:0] wip_v);
    if (src) return wip_v;
    return host_v;
  endfunction

  task automatic sweep(input string tag);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      rd_ptr = 2'(p);
      #1;
      check_eq(tag, int'(rd_data), int'(model[p]));
    end
    check_eq("R10 recall", int'(recall_val), int'(model[0]));
  endtask

  // Wait out a running write; returns busy length, checks old value meanwhile.
  task automatic ride_busy(input logic [5:0] oldv, input bit inject, input logic [1:0] ptr,
                           output int n);
    n = 0;
    while (write_busy && n < CYC + 4) begin
      if (n == 0) check_eq("R11 old value while busy", int'(rd_data), int'(oldv));
      if (inject && n == 3) begin
        req_valid = 1'b1; req_src = 1'b0; req_ptr = ptr ^ 2'd1; req_data = ~model[ptr ^ 2'd1];
      end
      if (inject && n == 4) begin
        check_eq("R9 drop flag", int'(req_dropped), 1);
        req_valid = 1'b0;
      end
      if (inject && n == 5) check_eq("R9 drop flag one cycle", int'(req_dropped), 0);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_frame(input logic src, input logic [1:0] ptr, input logic [5:0] data,
                           input logic [5:0] wip, input logic prot_n, input logic complete,
                           input bit inject);
    logic commit;
    logic [5:0] newv, oldv;
    int n;
    commit = prot_n && complete;
    newv   = expect_value(src, data, wip);
    oldv   = model[ptr];
    @(negedge clk);
    req_valid = 1'b1; req_src = src; req_ptr = ptr; req_data = data; wiper_val = wip;
    rd_ptr = ptr;
    @(negedge clk);
    req_valid = 1'b0; req_data = ~data; wiper_val = ~wip;
    frame_end = 1'b1; frame_complete = complete; wr_protect_n = prot_n;
    check_eq("R3 no change before commit", int'(rd_data), int'(oldv));
    @(negedge clk);
    frame_end = 1'b0; frame_complete = 1'b0; wr_protect_n = 1'b1;
    if (commit) begin
      ride_busy(oldv, inject, ptr, n);
      check_eq("R5 busy length", n, CYC);
      check_eq(src ? "R4 wiper copy committed" : "R6 value with busy fall",
               int'(rd_data), int'(newv));
      model[ptr] = newv;
      if (inject) begin
        @(negedge clk);
        frame_end = 1'b1; frame_complete = 1'b1;
        @(negedge clk);
        frame_end = 1'b0; frame_complete = 1'b0;
        check_eq("R9 dropped request not committed", int'(write_busy), 0);
      end
    end else begin
      check_eq(prot_n ? "R8 incomplete frame no busy" : "R7 protect no busy",
               int'(write_busy), 0);
      @(negedge clk);
      check_eq(prot_n ? "R8 incomplete frame no write" : "R7 protect no write",
               int'(rd_data), int'(oldv));
    end
    check_eq("R10 recall follows register zero", int'(recall_val), int'(model[0]));
  endtask

  initial begin : watchdog
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n;
    void'($urandom(32'd1729));
    rst_n = 1'b0; por_clear = 1'b1; req_valid = 1'b0; req_src = 1'b0; req_ptr = '0;
    req_data = '0; wiper_val = '0; frame_end = 1'b0; frame_complete = 1'b0;
    wr_protect_n = 1'b1; rd_ptr = '0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_clear = 1'b0;
    @(negedge clk);
    check_eq("R1 busy after reset", int'(write_busy), 0);
    check_eq("R1 drop after reset", int'(req_dropped), 0);
    sweep("R2 cleared by power-on");

    // Directed: each register, host and wiper sources.
    run_frame(1'b0, 2'd0, 6'd63, 6'd5, 1'b1, 1'b1, 1'b0);
    run_frame(1'b1, 2'd3, 6'd1, 6'd42, 1'b1, 1'b1, 1'b0);
    run_frame(1'b0, 2'd1, 6'd17, 6'd0, 1'b0, 1'b1, 1'b0);
    run_frame(1'b0, 2'd2, 6'd33, 6'd0, 1'b1, 1'b0, 1'b0);
    run_frame(1'b0, 2'd2, 6'd33, 6'd9, 1'b1, 1'b1, 1'b1);

    // R12: two requests in one frame, last wins.
    @(negedge clk);
    req_valid = 1'b1; req_src = 1'b0; req_ptr = 2'd1; req_data = 6'd11;
    @(negedge clk);
    req_ptr = 2'd1; req_data = 6'd22;
    @(negedge clk);
    req_valid = 1'b0; frame_end = 1'b1; frame_complete = 1'b1; rd_ptr = 2'd1;
    @(negedge clk);
    frame_end = 1'b0; frame_complete = 1'b0;
    ride_busy(model[1], 1'b0, 2'd1, n);
    check_eq("R12 last request wins", int'(rd_data), 22);
    model[1] = 6'd22;

    // Constrained random frames.
    for (int k = 0; k < 40; k++) begin
      run_frame(1'($urandom % 2), 2'($urandom % 4), 6'($urandom), 6'($urandom),
                1'(($urandom % 4) != 0), 1'(($urandom % 5) != 0), ($urandom % 3) == 0);
    end

    // R1: logic reset keeps storage.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 busy low after second reset", int'(write_busy), 0);
    sweep("R1 storage kept across reset");

    // R2: power-on model clears again.
    @(negedge clk);
    por_clear = 1'b1;
    @(negedge clk);
    por_clear = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    sweep("R2 cleared by second power-on");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule